// File: doc/BRIEF.md
# Translation Buffer Fill and Invalidate Controller

This block holds two small fully associative address translation buffers, one for data and one for instruction fetch. Software loads them through a register write port. On the data side, loading takes two steps. A write to the staged page-table-entry register only stores the value. A later write to the data tag register creates the entry. The new entry takes its fields from the staged value and its address-space number from the current data ASN register. On the instruction side, the tag is written first. The page-table-entry write then creates the entry at once, and the entry's write-enable field is forced to zero.

Each side accepts three invalidate commands: drop every entry, drop only the process-local entries, and drop the one entry that matches a given virtual address. Each side has a combinational lookup port. A lookup returns a hit flag, the physical page number and the permission bits. An entry matches a lookup when the tags are equal and either the entry is global or its ASN equals the current ASN of that side. Inserts and invalidates take effect on the clock edge that samples the write.

Top module: `tlb_fill_ctrl`

## Requirements
- R1: After reset no lookup on either side hits, every readable register reads zero and `gh_err` is low.
- R2: A write to the staged data PTE register (`wr_sel`=0) does not change any lookup result. A later write to the data tag register (`wr_sel`=1) inserts an entry on that clock edge. The entry's tag is bits 42:13 of the written value. Its fields come from the staged value and its ASN from the data ASN register. The staged value uses this layout: PPN at 58:32, read enables at 11:8, write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4, granularity hint at 6:5.
- R3: On the instruction side, the tag register (`wr_sel`=4) is written first. A write to the instruction PTE register (`wr_sel`=3) then inserts an entry with that tag and the instruction ASN (`wr_sel`=5). The entry's write-enable field is zero whatever value was written.
- R4: A lookup hits when the page tags are equal and either the entry's global bit is set or its ASN equals the current ASN of that side. `d_perm` and `i_perm` are {write enables[9:6], read enables[5:2], fault-on-write[1], fault-on-read[0]}. The PPN output reads zero on a miss.
- R5: An insert whose granularity hint (PTE bits 6:5) is nonzero is rejected and changes no entry. `gh_err` is high for exactly the one cycle after the rejected write.
- R6: Invalidate-all (`wr_sel` 6 for data, 9 for instruction) removes every entry of that side only. The command register reads back zero.
- R7: Invalidate-process (`wr_sel` 7 or 10) removes only the entries whose global bit is clear. The command register reads back zero.
- R8: Invalidate-single (`wr_sel` 8 or 11) removes the entries that a lookup of the written address under the current ASN would hit. It leaves a local entry with another ASN. The register reads back the written value.
- R9: With DEPTH entries, inserts fill slots in round-robin order. The (DEPTH+1)-th distinct insert after reset evicts the first one.
- R10: An insert whose tag and ASN equal those of a valid entry overwrites that entry and does not move the round-robin pointer.
- R11: Reading the PTE register of a side (`rd_sel` 0 or 3) returns that side's most recently inserted entry. The PPN is at 58:32, read enables at 11:8, write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2 and global at bit 4. The ASN is ORed into 63:57.
- R12: The ASN registers (`wr_sel` 2 and 5) keep only bits 6:0 of the written value, and they read back that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register written |
| wr_data | input | 64 | Write value |
| rd_sel | input | 4 | Register read |
| rd_data | output | 64 | Combinational read value |
| d_va | input | 43 | Data lookup virtual address |
| d_hit | output | 1 | Data lookup hit |
| d_ppn | output | 27 | Data lookup page number |
| d_perm | output | 10 | Data lookup permissions |
| i_va | input | 43 | Instruction lookup virtual address |
| i_hit | output | 1 | Instruction lookup hit |
| i_ppn | output | 27 | Instruction lookup page number |
| i_perm | output | 10 | Instruction lookup permissions |
| gh_err | output | 1 | Rejected-insert flag, one cycle |

## Verification
Lookups and register reads have no register in their path. Inserts, invalidates and register updates become visible one clock after the write is sampled. `gh_err` is registered, so it rises one clock after the rejected write and falls on the next clock. The bench drives each write on a falling edge and removes it after one rising edge. It then checks lookups and reads on the following falling edge, which is the first point where the update is due. For the error flag, it checks high at that point and low one clock later.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

  typedef enum logic [3:0] {
    SEL_DPTE      = 4'd0,
    SEL_DTAG      = 4'd1,
    SEL_DASN      = 4'd2,
    SEL_IPTE      = 4'd3,
    SEL_ITAG      = 4'd4,
    SEL_IASN      = 4'd5,
    SEL_DINV_ALL  = 4'd6,
    SEL_DINV_PROC = 4'd7,
    SEL_DINV_ONE  = 4'd8,
    SEL_IINV_ALL  = 4'd9,
    SEL_IINV_PROC = 4'd10,
    SEL_IINV_ONE  = 4'd11
  } sel_e;

  typedef struct packed {
    logic [26:0] ppn;
    logic [3:0]  rd_en;
    logic [3:0]  wr_en;
    logic        f_rd;
    logic        f_wr;
    logic        gbl;
    logic [6:0]  asn;
  } pte_t;

  // decode a software PTE word; ASN filled in by the caller
  function automatic pte_t unpack_pte(input logic [63:0] w);
    pte_t e;
    e.ppn   = w[58:32];
    e.rd_en = w[11:8];
    e.wr_en = w[15:12];
    e.f_rd  = w[1];
    e.f_wr  = w[2];
    e.gbl   = w[4];
    e.asn   = '0;
    return e;
  endfunction

  function automatic logic [1:0] gh_field(input logic [63:0] w);
    return w[6:5];
  endfunction

  // readback layout; ASN overlaps the top PPN bits and is ORed in
  function automatic logic [63:0] pack_pte(input pte_t e);
    logic [63:0] w;
    w          = '0;
    w[58:32]   = e.ppn;
    w[11:8]    = e.rd_en;
    w[15:12]   = e.wr_en;
    w[1]       = e.f_rd;
    w[2]       = e.f_wr;
    w[4]       = e.gbl;
    w[63:57]   = w[63:57] | e.asn;
    return w;
  endfunction

  function automatic logic [9:0] perm_of(input pte_t e);
    return {e.wr_en, e.rd_en, e.f_wr, e.f_rd};
  endfunction

endpackage

// File: rtl/tlbc_array.sv
module tlbc_array
  import tlbc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  pte_t             ins_pte,
  input  logic             inv_all,
  input  logic             inv_proc,
  input  logic             inv_one,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic [6:0]       cur_asn,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output pte_t             lk_pte,
  output pte_t             last_pte
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST_SLOT = IW'(DEPTH - 1);

  logic [DEPTH-1:0] valid_q;
  pte_t             ent_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IW-1:0]    rr_q, last_q, victim, lk_idx;

  // named per-slot events
  logic [DEPTH-1:0] same_vec, hit_vec, inv_hit_vec, gbl_vec;
  logic             same_any;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign gbl_vec[g]     = ent_q[g].gbl;
    assign same_vec[g]    = valid_q[g] && tag_q[g] == ins_tag && ent_q[g].asn == ins_pte.asn;
    assign hit_vec[g]     = valid_q[g] && tag_q[g] == lk_tag &&
                            (ent_q[g].gbl || ent_q[g].asn == cur_asn);
    assign inv_hit_vec[g] = valid_q[g] && tag_q[g] == inv_tag &&
                            (ent_q[g].gbl || ent_q[g].asn == cur_asn);
  end

  always_comb begin
    same_any = |same_vec;
    victim   = rr_q;
    lk_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (same_vec[i]) victim = IW'(i);
      if (hit_vec[i])  lk_idx = IW'(i);
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_pte   = ent_q[lk_idx];
  assign last_pte = ent_q[last_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      last_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (inv_proc) begin
      valid_q <= valid_q & gbl_vec;
    end else if (inv_one) begin
      valid_q <= valid_q & ~inv_hit_vec;
    end else if (ins_en) begin
      valid_q[victim] <= 1'b1;
      ent_q[victim]   <= ins_pte;
      tag_q[victim]   <= ins_tag;
      last_q          <= victim;
      if (!same_any) rr_q <= (rr_q == LAST_SLOT) ? '0 : rr_q + 1'b1;
    end
  end

  // R2
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_en, inv_all, inv_proc, inv_one}));
  // R9
  ins_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> valid_q[last_q]);
  // R6
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_q == '0);
  // R7
  inv_proc_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_proc |=> (valid_q & ~gbl_vec) == '0);
  // R10
  overwrite_keeps_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && same_any) |=> $stable(rr_q));

endmodule

// File: rtl/tlbc_regs.sv
module tlbc_regs
  import tlbc_pkg::*;
#(
  parameter int VA_W     = 43,
  parameter int PG_SHIFT = 13,
  localparam int TAG_W   = VA_W - PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_sel,
  input  logic [63:0]      wr_data,
  input  logic [3:0]       rd_sel,
  output logic [63:0]      rd_data,
  input  pte_t             d_last,
  input  pte_t             i_last,
  output logic             d_ins,
  output logic [TAG_W-1:0] d_ins_tag,
  output pte_t             d_ins_pte,
  output logic             d_inv_all,
  output logic             d_inv_proc,
  output logic             d_inv_one,
  output logic [6:0]       d_asn,
  output logic             i_ins,
  output logic [TAG_W-1:0] i_ins_tag,
  output pte_t             i_ins_pte,
  output logic             i_inv_all,
  output logic             i_inv_proc,
  output logic             i_inv_one,
  output logic [6:0]       i_asn,
  output logic [TAG_W-1:0] wr_tag,
  output logic             gh_err
);
  logic [63:0] dpte_q, dtag_q, itag_q, dinv_q, iinv_q;
  logic [6:0]  dasn_q, iasn_q;
  logic        gh_err_q;

  function automatic logic hit_sel(input logic en, input logic [3:0] s, input sel_e want);
    return en && (s == want);
  endfunction

  logic d_tag_wr, i_pte_wr, d_reject, i_reject;
  assign d_tag_wr = hit_sel(wr_en, wr_sel, SEL_DTAG);
  assign i_pte_wr = hit_sel(wr_en, wr_sel, SEL_IPTE);
  assign d_reject = d_tag_wr && gh_field(dpte_q) != 2'b00;
  assign i_reject = i_pte_wr && gh_field(wr_data) != 2'b00;

  assign wr_tag     = wr_data[VA_W-1:PG_SHIFT];
  assign d_ins      = d_tag_wr && !d_reject;
  assign d_ins_tag  = wr_tag;
  assign i_ins      = i_pte_wr && !i_reject;
  assign i_ins_tag  = itag_q[VA_W-1:PG_SHIFT];
  assign d_inv_all  = hit_sel(wr_en, wr_sel, SEL_DINV_ALL);
  assign d_inv_proc = hit_sel(wr_en, wr_sel, SEL_DINV_PROC);
  assign d_inv_one  = hit_sel(wr_en, wr_sel, SEL_DINV_ONE);
  assign i_inv_all  = hit_sel(wr_en, wr_sel, SEL_IINV_ALL);
  assign i_inv_proc = hit_sel(wr_en, wr_sel, SEL_IINV_PROC);
  assign i_inv_one  = hit_sel(wr_en, wr_sel, SEL_IINV_ONE);
  assign d_asn      = dasn_q;
  assign i_asn      = iasn_q;
  assign gh_err     = gh_err_q;

  always_comb begin
    d_ins_pte       = unpack_pte(dpte_q);
    d_ins_pte.asn   = dasn_q;
    i_ins_pte       = unpack_pte(wr_data);
    i_ins_pte.wr_en = '0;
    i_ins_pte.asn   = iasn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpte_q <= '0; dtag_q <= '0; itag_q <= '0;
      dinv_q <= '0; iinv_q <= '0;
      dasn_q <= '0; iasn_q <= '0;
      gh_err_q <= 1'b0;
    end else begin
      gh_err_q <= d_reject || i_reject;
      if (wr_en) begin
        unique case (wr_sel)
          SEL_DPTE:     dpte_q <= wr_data;
          SEL_DTAG:     dtag_q <= wr_data;
          SEL_DASN:     dasn_q <= wr_data[6:0];
          SEL_ITAG:     itag_q <= wr_data;
          SEL_IASN:     iasn_q <= wr_data[6:0];
          SEL_DINV_ONE: dinv_q <= wr_data;
          SEL_IINV_ONE: iinv_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_DPTE:     rd_data = pack_pte(d_last);
      SEL_DTAG:     rd_data = dtag_q;
      SEL_DASN:     rd_data = {57'd0, dasn_q};
      SEL_IPTE:     rd_data = pack_pte(i_last);
      SEL_ITAG:     rd_data = itag_q;
      SEL_IASN:     rd_data = {57'd0, iasn_q};
      SEL_DINV_ONE: rd_data = dinv_q;
      SEL_IINV_ONE: rd_data = iinv_q;
      default:      rd_data = '0;
    endcase
  end

  // R5
  gh_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gh_err |-> $past(wr_en));
  // R5
  gh_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gh_err && !$past(wr_en, 1)) |-> 1'b0);

endmodule

// File: rtl/tlb_fill_ctrl.sv
module tlb_fill_ctrl
  import tlbc_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int VA_W     = 43,
  parameter int PG_SHIFT = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [63:0]     wr_data,
  input  logic [3:0]      rd_sel,
  output logic [63:0]     rd_data,
  input  logic [VA_W-1:0] d_va,
  output logic            d_hit,
  output logic [26:0]     d_ppn,
  output logic [9:0]      d_perm,
  input  logic [VA_W-1:0] i_va,
  output logic            i_hit,
  output logic [26:0]     i_ppn,
  output logic [9:0]      i_perm,
  output logic            gh_err
);
  localparam int TAG_W = VA_W - PG_SHIFT;

  pte_t             d_last, i_last, d_ins_pte, i_ins_pte, d_lk, i_lk;
  logic             d_ins, i_ins, d_inv_all, d_inv_proc, d_inv_one;
  logic             i_inv_all, i_inv_proc, i_inv_one;
  logic [TAG_W-1:0] d_ins_tag, i_ins_tag, wr_tag;
  logic [6:0]       d_asn, i_asn;

  tlbc_regs #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
    .d_last, .i_last,
    .d_ins, .d_ins_tag, .d_ins_pte, .d_inv_all, .d_inv_proc, .d_inv_one, .d_asn,
    .i_ins, .i_ins_tag, .i_ins_pte, .i_inv_all, .i_inv_proc, .i_inv_one, .i_asn,
    .wr_tag, .gh_err
  );

  tlbc_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dtb (
    .clk, .rst_n,
    .ins_en(d_ins), .ins_tag(d_ins_tag), .ins_pte(d_ins_pte),
    .inv_all(d_inv_all), .inv_proc(d_inv_proc), .inv_one(d_inv_one),
    .inv_tag(wr_tag), .cur_asn(d_asn),
    .lk_tag(d_va[VA_W-1:PG_SHIFT]), .lk_hit(d_hit), .lk_pte(d_lk), .last_pte(d_last)
  );

  tlbc_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_itb (
    .clk, .rst_n,
    .ins_en(i_ins), .ins_tag(i_ins_tag), .ins_pte(i_ins_pte),
    .inv_all(i_inv_all), .inv_proc(i_inv_proc), .inv_one(i_inv_one),
    .inv_tag(wr_tag), .cur_asn(i_asn),
    .lk_tag(i_va[VA_W-1:PG_SHIFT]), .lk_hit(i_hit), .lk_pte(i_lk), .last_pte(i_last)
  );

  assign d_ppn  = d_hit ? d_lk.ppn : '0;
  assign d_perm = d_hit ? perm_of(d_lk) : '0;
  assign i_ppn  = i_hit ? i_lk.ppn : '0;
  assign i_perm = i_hit ? perm_of(i_lk) : '0;

  // R3
  i_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_hit |-> i_perm[9:6] == 4'd0);
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !d_hit |-> (d_ppn == '0 && d_perm == '0));

endmodule

// File: tb/tlb_fill_ctrl_tb.sv
module tlb_fill_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [42:0] d_va = '0, i_va = '0;
  logic        d_hit, i_hit, gh_err;
  logic [26:0] d_ppn, i_ppn;
  logic [9:0]  d_perm, i_perm;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_fill_ctrl u_dut (.*);

  function automatic logic [63:0] mkpte(input int ppn, input int rd, input int wr,
                                        input int fr, input int fw, input int g, input int gh);
    logic [63:0] w;
    w = (64'(ppn) << 32) | (64'(wr & 15) << 12) | (64'(rd & 15) << 8) |
        (64'(gh & 3) << 5) | (64'(g & 1) << 4) | (64'(fw & 1) << 2) | (64'(fr & 1) << 1);
    return w;
  endfunction

  function automatic logic [42:0] va_of(input int tag);
    return 43'(tag) << 13;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic d_fill(input int tag, input logic [63:0] pte);
    wr(0, pte);
    wr(1, 64'(va_of(tag)));
  endtask

  task automatic d_look(input string req, input int tag, input bit hit, input int ppn);
    d_va = va_of(tag); #1;
    chk(req, {63'd0, d_hit}, {63'd0, hit});
    chk(req, {37'd0, d_ppn}, 64'(hit ? ppn : 0));
  endtask

  task automatic i_look(input string req, input int tag, input bit hit, input int ppn);
    i_va = va_of(tag); #1;
    chk(req, {63'd0, i_hit}, {63'd0, hit});
    chk(req, {37'd0, i_ppn}, 64'(hit ? ppn : 0));
  endtask

  task automatic rd(input string req, input int sel, input logic [63:0] exp);
    rd_sel = 4'(sel); #1;
    chk(req, rd_data, exp);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 12; s++) rd("R1 read zero", s, 64'd0);
    d_look("R1 no data hit", 0, 0, 0);
    i_look("R1 no instr hit", 0, 0, 0);
    chk("R1 gh_err", {63'd0, gh_err}, 64'd0);
  endtask

  task automatic t_dfill;
    wr(2, 64'h0000_0000_0000_FF85);
    rd("R12 asn low bits", 2, 64'h5);
    wr(0, mkpte(27'h123, 4'hA, 4'h5, 1, 0, 0, 0));
    d_look("R2 staged only", 16'h10, 0, 0);
    wr(1, 64'(va_of(16'h10)));
    d_look("R2 insert", 16'h10, 1, 27'h123);
    chk("R4 perm layout", {54'd0, d_perm}, {54'd0, 4'h5, 4'hA, 1'b0, 1'b1});
    rd("R11 readback", 0, (64'h123 << 32) | (64'd5 << 57) | (64'h5 << 12) | (64'hA << 8) | 64'h2);
  endtask

  task automatic t_asn_match;
    wr(2, 64'd6);
    d_look("R4 asn mismatch", 16'h10, 0, 0);
    d_fill(16'h20, mkpte(27'h200, 4'h1, 0, 0, 0, 1, 0));
    wr(2, 64'd7);
    d_look("R4 global hit", 16'h20, 1, 27'h200);
    d_look("R4 local other asn", 16'h10, 0, 0);
    wr(2, 64'd5);
    d_look("R4 asn back", 16'h10, 1, 27'h123);
  endtask

  task automatic t_ifill;
    wr(5, 64'd3);
    wr(4, 64'(va_of(16'h40)));
    i_look("R3 none before pte", 16'h40, 0, 0);
    wr(3, mkpte(27'h77, 4'hF, 4'hF, 0, 1, 0, 0));
    i_look("R3 insert", 16'h40, 1, 27'h77);
    chk("R3 wr forced zero", {54'd0, i_perm}, {54'd0, 4'h0, 4'hF, 1'b1, 1'b0});
    d_look("R3 data side apart", 16'h40, 0, 0);
    rd("R11 instr readback", 3, (64'h77 << 32) | (64'd3 << 57) | (64'hF << 8) | 64'h4);
  endtask

  task automatic t_gh;
    wr(0, mkpte(27'h50, 4'h1, 0, 0, 0, 0, 1));
    wr(1, 64'(va_of(16'h50)));
    chk("R5 err high", {63'd0, gh_err}, 64'd1);
    @(negedge clk); #1;
    chk("R5 err one cycle", {63'd0, gh_err}, 64'd0);
    d_look("R5 rejected data", 16'h50, 0, 0);
    wr(4, 64'(va_of(16'h51)));
    wr(3, mkpte(27'h51, 4'h1, 0, 0, 0, 0, 2));
    chk("R5 instr err", {63'd0, gh_err}, 64'd1);
    i_look("R5 rejected instr", 16'h51, 0, 0);
  endtask

  task automatic t_inv;
    d_fill(16'h60, mkpte(27'h60, 1, 0, 0, 0, 0, 0));
    d_fill(16'h61, mkpte(27'h61, 1, 0, 0, 0, 1, 0));
    wr(7, 64'd1);
    d_look("R7 local gone", 16'h60, 0, 0);
    d_look("R7 global kept", 16'h61, 1, 27'h61);
    rd("R7 reads zero", 7, 64'd0);
    d_fill(16'h70, mkpte(27'h70, 1, 0, 0, 0, 0, 0));
    d_fill(16'h71, mkpte(27'h71, 1, 0, 0, 0, 0, 0));
    wr(2, 64'd9);
    d_fill(16'h72, mkpte(27'h72, 1, 0, 0, 0, 0, 0));
    wr(2, 64'd5);
    wr(8, 64'(va_of(16'h70)));
    d_look("R8 single gone", 16'h70, 0, 0);
    d_look("R8 neighbour kept", 16'h71, 1, 27'h71);
    rd("R8 reads value", 8, 64'(va_of(16'h70)));
    wr(8, 64'(va_of(16'h72)));
    wr(2, 64'd9);
    d_look("R8 other asn kept", 16'h72, 1, 27'h72);
    wr(6, 64'd1);
    d_look("R6 all gone", 16'h72, 0, 0);
    d_look("R6 global gone", 16'h61, 0, 0);
    rd("R6 reads zero", 6, 64'd0);
    i_look("R6 instr untouched", 16'h40, 1, 27'h77);
    wr(9, 64'd1);
    i_look("R6 instr all gone", 16'h40, 0, 0);
  endtask

  task automatic t_rr;
    do_reset();
    wr(2, 64'd1);
    for (int t = 1; t <= 8; t++) d_fill(t, mkpte(t, 1, 0, 0, 0, 0, 0));
    d_fill(3, mkpte(27'h333, 1, 0, 0, 0, 0, 0));
    d_look("R10 overwrite", 3, 1, 27'h333);
    d_fill(9, mkpte(9, 1, 0, 0, 0, 0, 0));
    d_look("R9 oldest evicted", 1, 0, 0);
    d_look("R10 no extra eviction", 2, 1, 2);
    for (int t = 4; t <= 9; t++) d_look("R9 kept", t, 1, t);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_dfill();
    t_asn_match();
    t_ifill();
    t_gh();
    t_inv();
    t_rr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule